// File: doc/BRIEF.md
# Task Slot Scheduler with Exclusive Lock

This block chooses, on every clock, which of several hardware tasks may issue into a pipeline they all share. With no lock held, issue slots rotate round-robin. A task is skipped while it is disabled or while it reports a stall. A task can take exclusive use of the pipeline with a lock strobe. From then on it receives every slot, even while it stalls and spins, until it gives the pipeline back with a free strobe.

A request to swap out the running thread is honoured only while no lock is held. A request made during a lock is kept pending and is granted as a single-cycle pulse once the lock is gone. Locks are meant to be short, about as long as the slowest long-latency result. A hold counter raises an overrun flag when a lock lasts longer than a configurable number of cycles. One such case is a holder spinning on a resource whose owner can never run.

All outputs are registered. A decision made from the inputs sampled at a clock edge is visible on the outputs right after that edge.

Top module: `slot_sched`

## Requirements
- R1: While reset is asserted and after it is released, issue_valid, swap_grant, locked and hold_overrun are 0. The first task issued after reset is the lowest-numbered eligible task, task 0 when all are eligible.
- R2: With no lock held, the issued task is the first eligible task after the one issued last, in ascending order with wrap-around. A task is eligible when its task_en bit is 1 and its task_stall bit is 0. Bit i of each mask belongs to task i.
- R3: With no lock held and no eligible task, issue_valid is 0 and the rotation position is kept.
- R4: A lock_req with cmd_tid = t, sampled while no lock is held, sets locked and gives every following slot to task t, whatever the task_en and task_stall values. This holds from the outputs after that same edge.
- R5: A lock_req sampled while a lock is held is ignored. A free_req whose cmd_tid is not the holder's is ignored.
- R6: A free_req from the holder clears locked after that edge. Rotation then resumes with the first eligible task after the holder.
- R7: A swap_req is remembered until granted. swap_grant is never 1 while locked is 1, and a lock taken at the same edge as a swap_req defers that request.
- R8: swap_grant is a one-cycle pulse on the first output cycle with locked = 0 and a request pending, and it consumes the request.
- R9: hold_overrun is 1 when the current lock has been held for more than HOLD_LIMIT consecutive output cycles. It returns to 0 when the lock is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| task_en | input | NUM_TASKS | Per-task enable mask |
| task_stall | input | NUM_TASKS | Per-task stall indication |
| lock_req | input | 1 | Lock strobe from task cmd_tid |
| free_req | input | 1 | Free strobe from task cmd_tid |
| cmd_tid | input | TID_W | Task ID tagging the lock or free strobe |
| swap_req | input | 1 | Preemptive thread-swap request |
| issue_valid | output | 1 | A task is issued in this slot |
| issue_tid | output | TID_W | Task issued in this slot |
| swap_grant | output | 1 | One-cycle thread-swap grant |
| locked | output | 1 | A lock is held |
| hold_overrun | output | 1 | Lock held past HOLD_LIMIT cycles |

## Verification
The hardest situation to reach is the starvation deadlock. The holder is stalled, spinning on a resource, while the task that owns that resource stays eligible but never runs. The stimulus takes the lock for task 1 and raises task 1's stall. It keeps task 2 enabled and unstalled, then checks that every slot goes to task 1 until the overrun flag rises exactly one cycle past the limit. A swap request is left pending across a lock and across a reset taken mid-lock, to show that it is deferred in the first case and discarded in the second.

// File: rtl/slot_sched_pkg.sv
package slot_sched_pkg;
    localparam int DEF_TASKS      = 4;
    localparam int DEF_HOLD_LIMIT = 20;

    function automatic int tid_bits(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction
endpackage

// File: rtl/slot_rr_pick.sv
module slot_rr_pick #(
    parameter int N     = 4,
    parameter int TID_W = 2
) (
    input  logic [N-1:0]     elig,
    input  logic [TID_W-1:0] last,
    output logic             found,
    output logic [TID_W-1:0] pick
);
    always_comb begin
        found = 1'b0;
        pick  = last;
        // walk offsets from farthest to nearest so the nearest eligible wins
        for (int off = N; off >= 1; off--) begin
            int idx;
            idx = (int'(last) + off) % N;
            if (elig[idx]) begin
                found = 1'b1;
                pick  = TID_W'(idx);
            end
        end
    end
endmodule

// File: rtl/slot_hold_watch.sv
module slot_hold_watch #(
    parameter int HOLD_LIMIT = 20
) (
    input  logic clk,
    input  logic rst_n,
    input  logic held_d,
    input  logic fresh,
    output logic overrun
);
    localparam int SAT   = HOLD_LIMIT + 1;
    localparam int CNT_W = $clog2(SAT + 1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             over;
    } watch_t;

    watch_t w_d, w_q;

    always_comb begin
        w_d = w_q;
        if (!held_d)
            w_d.cnt = '0;
        else if (fresh)
            w_d.cnt = CNT_W'(1);
        else if (w_q.cnt != CNT_W'(SAT))
            w_d.cnt = w_q.cnt + 1'b1;
        w_d.over = held_d && (w_d.cnt > CNT_W'(HOLD_LIMIT));
    end

    always_ff @(posedge clk) begin
        if (!rst_n) w_q <= '0;
        else        w_q <= w_d;
    end

    assign overrun = w_q.over;
endmodule

// File: rtl/slot_sched.sv
module slot_sched
    import slot_sched_pkg::*;
#(
    parameter int NUM_TASKS  = DEF_TASKS,
    parameter int HOLD_LIMIT = DEF_HOLD_LIMIT,
    parameter int TID_W      = tid_bits(NUM_TASKS)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_TASKS-1:0] task_en,
    input  logic [NUM_TASKS-1:0] task_stall,
    input  logic                 lock_req,
    input  logic                 free_req,
    input  logic [TID_W-1:0]     cmd_tid,
    input  logic                 swap_req,
    output logic                 issue_valid,
    output logic [TID_W-1:0]     issue_tid,
    output logic                 swap_grant,
    output logic                 locked,
    output logic                 hold_overrun
);
    localparam logic [TID_W-1:0] LAST_INIT = TID_W'(NUM_TASKS - 1);

    typedef struct packed {
        logic             held;
        logic [TID_W-1:0] owner;
        logic [TID_W-1:0] last;
        logic             pend;
        logic             valid;
        logic [TID_W-1:0] issue;
        logic             grant;
    } sched_t;

    sched_t s_d, s_q;

    logic             rr_found;
    logic [TID_W-1:0] rr_pick;
    logic             lock_ok;
    logic             free_ok;
    logic             pend_any;

    slot_rr_pick #(.N(NUM_TASKS), .TID_W(TID_W)) u_pick (
        .elig  (task_en & ~task_stall),
        .last  (s_q.last),
        .found (rr_found),
        .pick  (rr_pick)
    );

    always_comb begin
        s_d       = s_q;
        s_d.grant = 1'b0;

        lock_ok = lock_req && !s_q.held;
        free_ok = free_req && s_q.held && (cmd_tid == s_q.owner);

        if (lock_ok) begin
            s_d.held  = 1'b1;
            s_d.owner = cmd_tid;
        end else if (free_ok) begin
            s_d.held = 1'b0;
        end

        if (s_d.held) begin
            s_d.valid = 1'b1;
            s_d.issue = s_d.owner;
            s_d.last  = s_d.owner;
        end else if (rr_found) begin
            s_d.valid = 1'b1;
            s_d.issue = rr_pick;
            s_d.last  = rr_pick;
        end else begin
            s_d.valid = 1'b0;
        end

        pend_any = s_q.pend || swap_req;
        if (pend_any && !s_d.held) begin
            s_d.grant = 1'b1;
            s_d.pend  = 1'b0;
        end else begin
            s_d.pend = pend_any;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q      <= '0;
            s_q.last <= LAST_INIT;
        end else begin
            s_q <= s_d;
        end
    end

    slot_hold_watch #(.HOLD_LIMIT(HOLD_LIMIT)) u_watch (
        .clk     (clk),
        .rst_n   (rst_n),
        .held_d  (s_d.held),
        .fresh   (lock_ok),
        .overrun (hold_overrun)
    );

    assign issue_valid = s_q.valid;
    assign issue_tid   = s_q.issue;
    assign swap_grant  = s_q.grant;
    assign locked      = s_q.held;
endmodule

// File: rtl/slot_sched_chk.sv
module slot_sched_chk #(
    parameter int N     = 4,
    parameter int TID_W = 2
) (
    input logic             clk,
    input logic             rst_n,
    input logic [N-1:0]     task_en,
    input logic [N-1:0]     task_stall,
    input logic             issue_valid,
    input logic [TID_W-1:0] issue_tid,
    input logic             swap_grant,
    input logic             locked,
    input logic             hold_overrun
);
    logic [N-1:0] elig_prev;

    always_ff @(posedge clk) begin
        if (!rst_n) elig_prev <= '0;
        else        elig_prev <= task_en & ~task_stall;
    end

    AST_RR_ELIGIBLE: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_valid && !locked) |-> elig_prev[issue_tid]); // R2

    AST_LOCK_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (locked && $past(locked)) |-> (issue_valid && issue_tid == $past(issue_tid))); // R4

    AST_NO_GRANT_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        locked |-> !swap_grant); // R7

    AST_OVERRUN_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        hold_overrun |-> locked); // R9

    AST_RESET_QUIET: assert property (@(posedge clk)
        $past(!rst_n) |-> (!issue_valid && !swap_grant && !locked && !hold_overrun)); // R1
endmodule

bind slot_sched slot_sched_chk #(.N(NUM_TASKS), .TID_W(TID_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .task_en      (task_en),
    .task_stall   (task_stall),
    .issue_valid  (issue_valid),
    .issue_tid    (issue_tid),
    .swap_grant   (swap_grant),
    .locked       (locked),
    .hold_overrun (hold_overrun)
);

// File: tb/slot_sched_test.sv
module slot_sched_test;
    localparam int NT    = 4;
    localparam int LIMIT = 20;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NT-1:0] task_en = '0;
    logic [NT-1:0] task_stall = '0;
    logic          lock_req = 1'b0;
    logic          free_req = 1'b0;
    logic [1:0]    cmd_tid = '0;
    logic          swap_req = 1'b0;
    logic          issue_valid;
    logic [1:0]    issue_tid;
    logic          swap_grant;
    logic          locked;
    logic          hold_overrun;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    slot_sched #(.NUM_TASKS(NT), .HOLD_LIMIT(LIMIT)) uut (
        .clk(clk), .rst_n(rst_n), .task_en(task_en), .task_stall(task_stall),
        .lock_req(lock_req), .free_req(free_req), .cmd_tid(cmd_tid),
        .swap_req(swap_req), .issue_valid(issue_valid), .issue_tid(issue_tid),
        .swap_grant(swap_grant), .locked(locked), .hold_overrun(hold_overrun)
    );

    typedef struct packed {
        logic [3:0] en;
        logic [3:0] st;
        logic       lk;
        logic       fr;
        logic [1:0] tid;
        logic       sw;
        logic       ev;
        logic [1:0] et;
        logic       eg;
        logic       el;
    } vec_t;

    // en, stall, lock, free, tid, swap | valid, tid, grant, locked
    localparam vec_t TBL [20] = '{
        '{4'hF, 4'h0, 0, 0, 2'd0, 0, 1, 2'd0, 0, 0}, // R1 first is task 0
        '{4'hF, 4'h0, 0, 0, 2'd0, 0, 1, 2'd1, 0, 0}, // R2
        '{4'hF, 4'h0, 0, 0, 2'd0, 0, 1, 2'd2, 0, 0}, // R2
        '{4'hF, 4'h0, 0, 0, 2'd0, 0, 1, 2'd3, 0, 0}, // R2
        '{4'hF, 4'h0, 0, 0, 2'd0, 0, 1, 2'd0, 0, 0}, // R2 wrap
        '{4'h5, 4'h0, 0, 0, 2'd0, 0, 1, 2'd2, 0, 0}, // R2 skip disabled
        '{4'h5, 4'h0, 0, 0, 2'd0, 0, 1, 2'd0, 0, 0}, // R2
        '{4'hF, 4'h2, 0, 0, 2'd0, 0, 1, 2'd2, 0, 0}, // R2 skip stalled
        '{4'hF, 4'h0, 1, 0, 2'd3, 0, 1, 2'd3, 0, 1}, // R4 task 3 locks
        '{4'hF, 4'h0, 0, 0, 2'd0, 1, 1, 2'd3, 0, 1}, // R7 swap deferred
        '{4'hF, 4'h0, 1, 0, 2'd1, 0, 1, 2'd3, 0, 1}, // R5 second lock ignored
        '{4'hF, 4'h0, 0, 1, 2'd0, 0, 1, 2'd3, 0, 1}, // R5 foreign free ignored
        '{4'hF, 4'h8, 0, 0, 2'd0, 0, 1, 2'd3, 0, 1}, // R4 holder stalled still issues
        '{4'hF, 4'h0, 0, 1, 2'd3, 0, 1, 2'd0, 1, 0}, // R6 R8 release, grant
        '{4'hF, 4'h0, 0, 0, 2'd0, 0, 1, 2'd1, 0, 0}, // R8 pulse ends
        '{4'hF, 4'h0, 0, 0, 2'd0, 1, 1, 2'd2, 1, 0}, // R8 immediate grant
        '{4'h0, 4'h0, 0, 0, 2'd0, 0, 0, 2'd0, 0, 0}, // R3 nothing eligible
        '{4'hF, 4'h0, 0, 0, 2'd0, 0, 1, 2'd3, 0, 0}, // R3 position kept
        '{4'hF, 4'h0, 1, 0, 2'd0, 1, 1, 2'd0, 0, 1}, // R7 lock beats swap
        '{4'hF, 4'h0, 0, 1, 2'd0, 0, 1, 2'd1, 1, 0}  // R6 R8
    };

    task automatic chk(input string req, input int got, input int exp);
        n_chk++;
        if (got != exp) begin
            n_fail++;
            $display("FAIL %s: got %0d expected %0d", req, got, exp);
        end
    endtask

    task automatic idle_inputs();
        lock_req = 0; free_req = 0; swap_req = 0; cmd_tid = '0;
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        #(200000 * 10);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: got 0 expected 1 (run completion)");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 valid in reset", int'(issue_valid), 0);
        chk("R1 locked in reset", int'(locked), 0);
        chk("R1 grant in reset", int'(swap_grant), 0);
        chk("R1 overrun in reset", int'(hold_overrun), 0);
        rst_n = 1;

        for (int i = 0; i < 20; i++) begin
            task_en = TBL[i].en; task_stall = TBL[i].st;
            lock_req = TBL[i].lk; free_req = TBL[i].fr;
            cmd_tid = TBL[i].tid; swap_req = TBL[i].sw;
            @(negedge clk);
            chk($sformatf("R2 table %0d valid", i), int'(issue_valid), int'(TBL[i].ev));
            if (TBL[i].ev)
                chk($sformatf("R2 table %0d tid", i), int'(issue_tid), int'(TBL[i].et));
            chk($sformatf("R8 table %0d grant", i), int'(swap_grant), int'(TBL[i].eg));
            chk($sformatf("R4 table %0d locked", i), int'(locked), int'(TBL[i].el));
        end

        // R9 deadlock: task 1 locks and spins stalled, task 2 eligible but starved
        idle_inputs();
        task_en = 4'hF; task_stall = 4'h0;
        lock_req = 1; cmd_tid = 2'd1;
        @(negedge clk);
        idle_inputs();
        task_stall = 4'h2;
        for (int k = 1; k <= LIMIT + 1; k++) begin
            if (k > 1) @(negedge clk);
            chk("R4 deadlock holder owns slot", int'(issue_tid), 1);
            chk("R9 overrun timing", int'(hold_overrun), (k > LIMIT) ? 1 : 0);
        end
        @(negedge clk);
        chk("R9 overrun stays", int'(hold_overrun), 1);
        task_stall = 4'h0;
        free_req = 1; cmd_tid = 2'd1;
        @(negedge clk);
        idle_inputs();
        chk("R9 overrun cleared", int'(hold_overrun), 0);
        chk("R6 resume after holder", int'(issue_tid), 2);

        // R1 reset during lock with pending swap
        lock_req = 1; cmd_tid = 2'd2;
        @(negedge clk);
        idle_inputs();
        swap_req = 1;
        @(negedge clk);
        idle_inputs();
        chk("R7 pending, no grant", int'(swap_grant), 0);
        rst_n = 0;
        @(negedge clk);
        chk("R1 reset clears lock", int'(locked), 0);
        rst_n = 1;
        @(negedge clk);
        chk("R1 restart at task 0", int'(issue_tid), 0);
        chk("R1 pending swap discarded", int'(swap_grant), 0);
        @(negedge clk);
        chk("R1 no late grant", int'(swap_grant), 0);

        finish_run();
    end
endmodule